// File: doc/BRIEF.md
# Integer Operate Execution Unit

This block is the integer execution stage for register-to-register operations in a 64-bit load/store processor core. Every accepted operation presents a 7-bit function code and a first operand. The second operand is either a register value or an 8-bit immediate, chosen by a select bit. A conditional move also presents the destination's present contents. The block returns a full-width result, a register write enable and an overflow trap flag.

The operations are:
- add and subtract, including forms that scale the second operand by 4 or 8;
- 32-bit variants whose results are sign-extended to full width;
- low and unsigned-high multiplication;
- compares that yield 0 or 1, with no condition codes;
- six bitwise logic functions;
- conditional moves that test the first operand against zero;
- logical and arithmetic shifts.

Unsigned carry is left to software. Software detects it with an unsigned compare of a sum against one of its operands.

Operations enter through a valid/ready request port. Results leave through a valid/ready response port after one register stage.

Back-pressure rules:
- A request transfers on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or being drained in that same cycle.
- While `out_valid` is high and `out_ready` is low, the response fields hold steady and no new request is taken.

Top module: `iop_exec_unit`

## Requirements
- R1: When `in_lit_sel` is 1, the second operand is `in_lit` zero-extended to 64 bits and `in_opb` is ignored. When `in_lit_sel` is 0, the second operand is `in_opb`.
- R2: Full-width add and subtract have eight codes: add 0x01, subtract 0x03, add with the second operand times 4 0x05, add with it times 8 0x07, subtract with it times 4 0x09, subtract with it times 8 0x0B. The trapping add 0x0D and trapping subtract 0x0F compute the same sum as their plain forms. All of these write the low 64 bits of the result with `out_we`=1.
- R3: The 32-bit forms are add 0x00, subtract 0x02, scaled add 0x04 (x4) and 0x06 (x8), scaled subtract 0x08 (x4) and 0x0A (x8), trapping add 0x0C, trapping subtract 0x0E, multiply 0x18 and trapping multiply 0x1B. They use only the low 32 bits of each operand and write the 32-bit result sign-extended to 64 bits.
- R4: Code 0x19 writes the low 64 bits of the product. Code 0x1A writes the upper 64 bits of the 128-bit unsigned product. Code 0x1C is the trapping full-width multiply and writes the low 64 bits.
- R5: Compares write 1 when the condition holds and 0 otherwise, with `out_we`=1. The codes are: equal 0x10, signed less-than 0x11, signed less-or-equal 0x12, unsigned less-than 0x13, unsigned less-or-equal 0x14.
- R6: The bitwise codes are AND 0x20, NAND 0x21, OR 0x22, NOR 0x23, XOR 0x24 and XNOR 0x25.
- R7: Conditional moves test `in_opa` as a signed value against zero. The codes are: eq 0x28, ne 0x29, lt 0x2A, le 0x2B, ge 0x2C, gt 0x2D. When the test holds, the result is the second operand with `out_we`=1. Otherwise `out_we`=0 and the result is `in_old_dest`.
- R8: The shift codes are logical left 0x30, logical right 0x31 and arithmetic right 0x32. The shift amount is only the low 6 bits of the second operand.
- R9: `out_ovf` is 1 only for the trapping codes 0x0C, 0x0D, 0x0E, 0x0F, 0x1B and 0x1C, and only when the signed result does not fit the destination width (32 bits for 0x0C, 0x0E and 0x1B; 64 bits for the others). Every other code gives `out_ovf`=0, even when the value wraps.
- R10: Any code not listed in R2 to R8 gives `out_we`=0, `out_ovf`=0 and `out_result`=0.
- R11: An accepted request appears at the response port on the next clock edge. `in_ready` equals `!out_valid || out_ready`.
- R12: While `out_valid`=1 and `out_ready`=0, `out_result`, `out_we` and `out_ovf` stay unchanged, `out_valid` stays 1, and no request is accepted.
- R13: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_fn | input | 7 | Function code |
| in_opa | input | XLEN | First operand |
| in_opb | input | XLEN | Second register operand |
| in_lit | input | LIT_W | Immediate operand |
| in_lit_sel | input | 1 | 1 selects the immediate as second operand |
| in_old_dest | input | XLEN | Current destination value for conditional moves |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Response can be taken |
| out_result | output | XLEN | Result value |
| out_we | output | 1 | Destination write enable |
| out_ovf | output | 1 | Overflow trap flag |

## Verification
The bench builds the unit with its defaults: XLEN of 64 and an 8-bit immediate. Immediates up to 255 can therefore select shift amounts above 63, which exercises the 6-bit masking of the shift count. The 128-bit unsigned product is reachable with all-ones operands, and the signed 32-bit and 64-bit wrap boundaries on the trapping and non-trapping forms are reachable from both register and immediate operands.

// File: rtl/iop_pkg.sv
package iop_pkg;

  localparam int FN_W = 7;

  // add / subtract family (bit 0 set selects full width)
  localparam logic [FN_W-1:0] FN_ADD_W32  = 7'h00;
  localparam logic [FN_W-1:0] FN_ADD_W64  = 7'h01;
  localparam logic [FN_W-1:0] FN_SUB_W32  = 7'h02;
  localparam logic [FN_W-1:0] FN_SUB_W64  = 7'h03;
  localparam logic [FN_W-1:0] FN_ADD4_W32 = 7'h04;
  localparam logic [FN_W-1:0] FN_ADD4_W64 = 7'h05;
  localparam logic [FN_W-1:0] FN_ADD8_W32 = 7'h06;
  localparam logic [FN_W-1:0] FN_ADD8_W64 = 7'h07;
  localparam logic [FN_W-1:0] FN_SUB4_W32 = 7'h08;
  localparam logic [FN_W-1:0] FN_SUB4_W64 = 7'h09;
  localparam logic [FN_W-1:0] FN_SUB8_W32 = 7'h0A;
  localparam logic [FN_W-1:0] FN_SUB8_W64 = 7'h0B;
  localparam logic [FN_W-1:0] FN_ADDT_W32 = 7'h0C;
  localparam logic [FN_W-1:0] FN_ADDT_W64 = 7'h0D;
  localparam logic [FN_W-1:0] FN_SUBT_W32 = 7'h0E;
  localparam logic [FN_W-1:0] FN_SUBT_W64 = 7'h0F;

  // compares
  localparam logic [FN_W-1:0] FN_CMP_EQ  = 7'h10;
  localparam logic [FN_W-1:0] FN_CMP_LT  = 7'h11;
  localparam logic [FN_W-1:0] FN_CMP_LE  = 7'h12;
  localparam logic [FN_W-1:0] FN_CMP_ULT = 7'h13;
  localparam logic [FN_W-1:0] FN_CMP_ULE = 7'h14;

  // multiply
  localparam logic [FN_W-1:0] FN_MUL_W32  = 7'h18;
  localparam logic [FN_W-1:0] FN_MUL_W64  = 7'h19;
  localparam logic [FN_W-1:0] FN_MUL_HIU  = 7'h1A;
  localparam logic [FN_W-1:0] FN_MULT_W32 = 7'h1B;
  localparam logic [FN_W-1:0] FN_MULT_W64 = 7'h1C;

  // bitwise
  localparam logic [FN_W-1:0] FN_AND  = 7'h20;
  localparam logic [FN_W-1:0] FN_NAND = 7'h21;
  localparam logic [FN_W-1:0] FN_OR   = 7'h22;
  localparam logic [FN_W-1:0] FN_NOR  = 7'h23;
  localparam logic [FN_W-1:0] FN_XOR  = 7'h24;
  localparam logic [FN_W-1:0] FN_XNOR = 7'h25;

  // conditional moves keyed on the first operand
  localparam logic [FN_W-1:0] FN_MOV_EQ = 7'h28;
  localparam logic [FN_W-1:0] FN_MOV_NE = 7'h29;
  localparam logic [FN_W-1:0] FN_MOV_LT = 7'h2A;
  localparam logic [FN_W-1:0] FN_MOV_LE = 7'h2B;
  localparam logic [FN_W-1:0] FN_MOV_GE = 7'h2C;
  localparam logic [FN_W-1:0] FN_MOV_GT = 7'h2D;

  // shifts
  localparam logic [FN_W-1:0] FN_SHL = 7'h30;
  localparam logic [FN_W-1:0] FN_SHR = 7'h31;
  localparam logic [FN_W-1:0] FN_SAR = 7'h32;

  // decoded control for the adder path
  typedef struct packed {
    logic       hit;
    logic [1:0] scale;
    logic       sub;
    logic       narrow;
    logic       trap;
  } arith_ctl_t;

  typedef enum logic [2:0] {
    CMP_NONE, CMP_EQ, CMP_LT, CMP_LE, CMP_ULT, CMP_ULE
  } cmp_kind_e;

endpackage

// File: rtl/iop_opsel.sv
module iop_opsel #(
  parameter int XLEN  = 64,
  parameter int LIT_W = 8
) (
  input  logic [XLEN-1:0]  reg_b,
  input  logic [LIT_W-1:0] lit,
  input  logic             lit_sel,
  output logic [XLEN-1:0]  opnd_b
);
  localparam int PAD_W = XLEN - LIT_W;

  always_comb begin
    if (lit_sel) opnd_b = {{PAD_W{1'b0}}, lit};
    else         opnd_b = reg_b;
  end
endmodule

// File: rtl/iop_arith.sv
module iop_arith
  import iop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [FN_W-1:0] fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            hit,
  output logic            ovf
);
  localparam int HW = XLEN / 2;

  arith_ctl_t      ctl;
  cmp_kind_e       cmp;
  logic [XLEN-1:0] b_sc;
  logic [XLEN-1:0] wsum;
  logic [HW-1:0]   nsum;
  logic            w_ovf;
  logic            n_ovf;
  logic            cbit;

  // decode of the adder family
  always_comb begin
    ctl = '0;
    ctl.hit = 1'b1;
    unique case (fn)
      FN_ADD_W32:  ctl.narrow = 1'b1;
      FN_ADD_W64:  ;
      FN_SUB_W32:  begin ctl.sub = 1'b1; ctl.narrow = 1'b1; end
      FN_SUB_W64:  ctl.sub = 1'b1;
      FN_ADD4_W32: begin ctl.scale = 2'd2; ctl.narrow = 1'b1; end
      FN_ADD4_W64: ctl.scale = 2'd2;
      FN_ADD8_W32: begin ctl.scale = 2'd3; ctl.narrow = 1'b1; end
      FN_ADD8_W64: ctl.scale = 2'd3;
      FN_SUB4_W32: begin ctl.scale = 2'd2; ctl.sub = 1'b1; ctl.narrow = 1'b1; end
      FN_SUB4_W64: begin ctl.scale = 2'd2; ctl.sub = 1'b1; end
      FN_SUB8_W32: begin ctl.scale = 2'd3; ctl.sub = 1'b1; ctl.narrow = 1'b1; end
      FN_SUB8_W64: begin ctl.scale = 2'd3; ctl.sub = 1'b1; end
      FN_ADDT_W32: begin ctl.trap = 1'b1; ctl.narrow = 1'b1; end
      FN_ADDT_W64: ctl.trap = 1'b1;
      FN_SUBT_W32: begin ctl.trap = 1'b1; ctl.sub = 1'b1; ctl.narrow = 1'b1; end
      FN_SUBT_W64: begin ctl.trap = 1'b1; ctl.sub = 1'b1; end
      default:     ctl.hit = 1'b0;
    endcase
  end

  // decode of the compare family
  always_comb begin
    unique case (fn)
      FN_CMP_EQ:  cmp = CMP_EQ;
      FN_CMP_LT:  cmp = CMP_LT;
      FN_CMP_LE:  cmp = CMP_LE;
      FN_CMP_ULT: cmp = CMP_ULT;
      FN_CMP_ULE: cmp = CMP_ULE;
      default:    cmp = CMP_NONE;
    endcase
  end

  // shared adder datapath
  always_comb begin
    b_sc = b << ctl.scale;
    if (ctl.sub) begin
      wsum = a - b_sc;
      nsum = a[HW-1:0] - b_sc[HW-1:0];
    end else begin
      wsum = a + b_sc;
      nsum = a[HW-1:0] + b_sc[HW-1:0];
    end
    // signed overflow: operand signs (after sub inversion) agree, result differs
    w_ovf = ((a[XLEN-1] ^ b_sc[XLEN-1]) == ctl.sub) && (wsum[XLEN-1] != a[XLEN-1]);
    n_ovf = ((a[HW-1] ^ b_sc[HW-1]) == ctl.sub) && (nsum[HW-1] != a[HW-1]);
  end

  always_comb begin
    unique case (cmp)
      CMP_EQ:  cbit = (a == b);
      CMP_LT:  cbit = ($signed(a) < $signed(b));
      CMP_LE:  cbit = ($signed(a) <= $signed(b));
      CMP_ULT: cbit = (a < b);
      CMP_ULE: cbit = (a <= b);
      default: cbit = 1'b0;
    endcase
  end

  always_comb begin
    hit = ctl.hit || (cmp != CMP_NONE);
    ovf = 1'b0;
    res = '0;
    if (ctl.hit) begin
      if (ctl.narrow) begin
        res = {{HW{nsum[HW-1]}}, nsum};
        ovf = ctl.trap && n_ovf;
      end else begin
        res = wsum;
        ovf = ctl.trap && w_ovf;
      end
    end else if (cmp != CMP_NONE) begin
      res = {{(XLEN-1){1'b0}}, cbit};
    end
  end
endmodule

// File: rtl/iop_mul.sv
module iop_mul
  import iop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [FN_W-1:0] fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            hit,
  output logic            ovf
);
  localparam int HW = XLEN / 2;
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   prod_u;
  logic [PW-1:0]   prod_s;
  logic [XLEN-1:0] prod_n;
  logic            wide_fit;
  logic            narrow_fit;

  always_comb begin
    prod_u = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    prod_s = {{XLEN{a[XLEN-1]}}, a} * {{XLEN{b[XLEN-1]}}, b};
    prod_n = {{HW{a[HW-1]}}, a[HW-1:0]} * {{HW{b[HW-1]}}, b[HW-1:0]};
    wide_fit   = (prod_s[PW-1:XLEN] == {XLEN{prod_s[XLEN-1]}});
    narrow_fit = (prod_n[XLEN-1:HW] == {HW{prod_n[HW-1]}});
  end

  always_comb begin
    hit = 1'b1;
    ovf = 1'b0;
    res = '0;
    unique case (fn)
      FN_MUL_W32:  res = {{HW{prod_n[HW-1]}}, prod_n[HW-1:0]};
      FN_MULT_W32: begin
        res = {{HW{prod_n[HW-1]}}, prod_n[HW-1:0]};
        ovf = !narrow_fit;
      end
      FN_MUL_W64:  res = prod_u[XLEN-1:0];
      FN_MULT_W64: begin
        res = prod_s[XLEN-1:0];
        ovf = !wide_fit;
      end
      FN_MUL_HIU:  res = prod_u[PW-1:XLEN];
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/iop_bitops.sv
module iop_bitops
  import iop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [FN_W-1:0] fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] old_dest,
  output logic [XLEN-1:0] res,
  output logic            we
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] sh;
  logic           a_zero;
  logic           a_neg;
  logic           mv_cond;
  logic           is_mov;

  always_comb begin
    sh     = b[SHW-1:0];
    a_zero = (a == '0);
    a_neg  = a[XLEN-1];
    is_mov = 1'b1;
    unique case (fn)
      FN_MOV_EQ: mv_cond = a_zero;
      FN_MOV_NE: mv_cond = !a_zero;
      FN_MOV_LT: mv_cond = a_neg;
      FN_MOV_LE: mv_cond = a_neg || a_zero;
      FN_MOV_GE: mv_cond = !a_neg;
      FN_MOV_GT: mv_cond = !a_neg && !a_zero;
      default: begin
        mv_cond = 1'b0;
        is_mov  = 1'b0;
      end
    endcase
  end

  always_comb begin
    we  = 1'b1;
    res = '0;
    if (is_mov) begin
      we  = mv_cond;
      res = mv_cond ? b : old_dest;
    end else begin
      unique case (fn)
        FN_AND:  res = a & b;
        FN_NAND: res = ~(a & b);
        FN_OR:   res = a | b;
        FN_NOR:  res = ~(a | b);
        FN_XOR:  res = a ^ b;
        FN_XNOR: res = ~(a ^ b);
        FN_SHL:  res = a << sh;
        FN_SHR:  res = a >> sh;
        FN_SAR:  res = $signed(a) >>> sh;
        default: we = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/iop_exec_unit.sv
module iop_exec_unit
  import iop_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LIT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FN_W-1:0]  in_fn,
  input  logic [XLEN-1:0]  in_opa,
  input  logic [XLEN-1:0]  in_opb,
  input  logic [LIT_W-1:0] in_lit,
  input  logic             in_lit_sel,
  input  logic [XLEN-1:0]  in_old_dest,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic             out_we,
  output logic             out_ovf
);
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] ar_res, mu_res, bo_res;
  logic            ar_hit, mu_hit, bo_we;
  logic            ar_ovf, mu_ovf;
  logic [XLEN-1:0] nx_res;
  logic            nx_we, nx_ovf;
  logic            take;

  iop_opsel #(.XLEN(XLEN), .LIT_W(LIT_W)) opsel_i (
    .reg_b   (in_opb),
    .lit     (in_lit),
    .lit_sel (in_lit_sel),
    .opnd_b  (opnd_b)
  );

  iop_arith #(.XLEN(XLEN)) arith_i (
    .fn  (in_fn),
    .a   (in_opa),
    .b   (opnd_b),
    .res (ar_res),
    .hit (ar_hit),
    .ovf (ar_ovf)
  );

  iop_mul #(.XLEN(XLEN)) mul_i (
    .fn  (in_fn),
    .a   (in_opa),
    .b   (opnd_b),
    .res (mu_res),
    .hit (mu_hit),
    .ovf (mu_ovf)
  );

  iop_bitops #(.XLEN(XLEN)) bitops_i (
    .fn       (in_fn),
    .a        (in_opa),
    .b        (opnd_b),
    .old_dest (in_old_dest),
    .res      (bo_res),
    .we       (bo_we)
  );

  // the three units decode disjoint code sets; the bitops path drives
  // zero with we low for codes it does not own
  always_comb begin
    if (ar_hit) begin
      nx_res = ar_res; nx_we = 1'b1; nx_ovf = ar_ovf;
    end else if (mu_hit) begin
      nx_res = mu_res; nx_we = 1'b1; nx_ovf = mu_ovf;
    end else begin
      nx_res = bo_res; nx_we = bo_we; nx_ovf = 1'b0;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_we     <= 1'b0;
      out_ovf    <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= nx_res;
      out_we     <= nx_we;
      out_ovf    <= nx_ovf;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/iop_exec_chk.sv
module iop_exec_chk
  import iop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [FN_W-1:0] in_fn,
  input logic [XLEN-1:0] in_opa,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_we,
  input logic            out_ovf
);
  localparam int HW = XLEN / 2;

  logic fire;
  logic trap_code;
  logic cmp_code;

  assign fire      = in_valid && in_ready;
  assign trap_code = (in_fn == FN_ADDT_W32) || (in_fn == FN_ADDT_W64) ||
                     (in_fn == FN_SUBT_W32) || (in_fn == FN_SUBT_W64) ||
                     (in_fn == FN_MULT_W32) || (in_fn == FN_MULT_W64);
  assign cmp_code  = (in_fn >= FN_CMP_EQ) && (in_fn <= FN_CMP_ULE);

  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_we) && $stable(out_ovf)));

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !trap_code) |=> !out_ovf);

  // R5
  cmp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmp_code) |=> (out_we && (out_result[XLEN-1:1] == '0)));

  // R7
  cmov_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_fn == FN_MOV_NE) && (in_opa == '0)) |=> !out_we);

  // R3
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_fn == FN_ADD_W32)) |=>
      (out_result[XLEN-1:HW] == {HW{out_result[HW-1]}}));

endmodule

bind iop_exec_unit iop_exec_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_fn      (in_fn),
  .in_opa     (in_opa),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_we     (out_we),
  .out_ovf    (out_ovf)
);

// File: tb/iop_exec_unit_tb_top.sv
module iop_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_fn = '0;
  logic [63:0] in_opa = '0;
  logic [63:0] in_opb = '0;
  logic [7:0]  in_lit = '0;
  logic        in_lit_sel = 1'b0;
  logic [63:0] in_old_dest = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_we;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iop_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fn(in_fn), .in_opa(in_opa), .in_opb(in_opb), .in_lit(in_lit),
    .in_lit_sel(in_lit_sel), .in_old_dest(in_old_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_we(out_we), .out_ovf(out_ovf)
  );

  function automatic logic [63:0] sx(input logic [31:0] x);
    return {{32{x[31]}}, x};
  endfunction

  function automatic string req_of(input logic [6:0] fn);
    if (fn inside {7'h00, 7'h02, 7'h04, 7'h06, 7'h08, 7'h0A, 7'h18}) return "R3";
    if (fn inside {7'h0C, 7'h0D, 7'h0E, 7'h0F, 7'h1B, 7'h1C}) return "R9";
    if (fn <= 7'h0F) return "R2";
    if (fn >= 7'h10 && fn <= 7'h14) return "R5";
    if (fn == 7'h19 || fn == 7'h1A) return "R4";
    if (fn >= 7'h20 && fn <= 7'h25) return "R6";
    if (fn >= 7'h28 && fn <= 7'h2D) return "R7";
    if (fn >= 7'h30 && fn <= 7'h32) return "R8";
    return "R10";
  endfunction

  // expected behaviour, from the requirement text
  function automatic void model(input logic [6:0] fn, input logic [63:0] a,
                                input logic [63:0] b, input logic [63:0] old,
                                output logic [63:0] r, output logic we,
                                output logic ov);
    logic [64:0]  s65;
    logic [32:0]  s33;
    logic [127:0] p;
    logic [63:0]  p64;
    logic         c;
    r = '0; we = 1'b1; ov = 1'b0; c = 1'b0;
    case (fn)
      7'h00, 7'h0C: begin
        s33 = {a[31], a[31:0]} + {b[31], b[31:0]};
        r = sx(s33[31:0]); ov = (fn == 7'h0C) && (s33[32] != s33[31]);
      end
      7'h02, 7'h0E: begin
        s33 = {a[31], a[31:0]} - {b[31], b[31:0]};
        r = sx(s33[31:0]); ov = (fn == 7'h0E) && (s33[32] != s33[31]);
      end
      7'h01, 7'h0D: begin
        s65 = {a[63], a} + {b[63], b};
        r = s65[63:0]; ov = (fn == 7'h0D) && (s65[64] != s65[63]);
      end
      7'h03, 7'h0F: begin
        s65 = {a[63], a} - {b[63], b};
        r = s65[63:0]; ov = (fn == 7'h0F) && (s65[64] != s65[63]);
      end
      7'h04: r = sx(32'(a[31:0] + b[31:0] * 4));
      7'h06: r = sx(32'(a[31:0] + b[31:0] * 8));
      7'h08: r = sx(32'(a[31:0] - b[31:0] * 4));
      7'h0A: r = sx(32'(a[31:0] - b[31:0] * 8));
      7'h05: r = a + b * 4;
      7'h07: r = a + b * 8;
      7'h09: r = a - b * 4;
      7'h0B: r = a - b * 8;
      7'h10: r = {63'b0, a == b};
      7'h11: r = {63'b0, $signed(a) < $signed(b)};
      7'h12: r = {63'b0, $signed(a) <= $signed(b)};
      7'h13: r = {63'b0, a < b};
      7'h14: r = {63'b0, a <= b};
      7'h18, 7'h1B: begin
        p64 = sx(a[31:0]) * sx(b[31:0]);
        r = sx(p64[31:0]);
        ov = (fn == 7'h1B) && !((p64[63:31] == '0) || (&p64[63:31]));
      end
      7'h19: r = a * b;
      7'h1A: begin p = {64'b0, a} * {64'b0, b}; r = p[127:64]; end
      7'h1C: begin
        p = {{64{a[63]}}, a} * {{64{b[63]}}, b};
        r = p[63:0];
        ov = !((p[127:63] == '0) || (&p[127:63]));
      end
      7'h20: r = a & b;
      7'h21: r = ~(a & b);
      7'h22: r = a | b;
      7'h23: r = ~(a | b);
      7'h24: r = a ^ b;
      7'h25: r = ~(a ^ b);
      7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D: begin
        case (fn)
          7'h28: c = ($signed(a) == 0);
          7'h29: c = ($signed(a) != 0);
          7'h2A: c = ($signed(a) < 0);
          7'h2B: c = ($signed(a) <= 0);
          7'h2C: c = ($signed(a) >= 0);
          default: c = ($signed(a) > 0);
        endcase
        we = c; r = c ? b : old;
      end
      7'h30: r = a << b[5:0];
      7'h31: r = a >> b[5:0];
      7'h32: r = $signed(a) >>> b[5:0];
      default: begin r = '0; we = 1'b0; end
    endcase
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // one operation, drained with out_ready high; result checked one edge later
  task automatic run_op(input logic [6:0] fn, input logic [63:0] a,
                        input logic [63:0] breg, input logic [7:0] lit,
                        input logic lsel, input logic [63:0] old,
                        input string rq);
    logic [63:0] be, r;
    logic we, ov;
    @(negedge clk);
    in_fn = fn; in_opa = a; in_opb = breg; in_lit = lit;
    in_lit_sel = lsel; in_old_dest = old; in_valid = 1'b1; out_ready = 1'b1;
    be = lsel ? {56'b0, lit} : breg;
    model(fn, a, be, old, r, we, ov);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == r && out_we == we && out_ovf == ov, rq,
          $sformatf("fn=%h", fn), {out_result, out_we, out_ovf}, {r, we, ov});
  endtask

  function automatic logic [6:0] pick_code(input int unsigned i);
    logic [6:0] t [41] = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h05, 7'h06,
      7'h07, 7'h08, 7'h09, 7'h0A, 7'h0B, 7'h0C, 7'h0D, 7'h0E, 7'h0F, 7'h10,
      7'h11, 7'h12, 7'h13, 7'h14, 7'h18, 7'h19, 7'h1A, 7'h1B, 7'h1C, 7'h20,
      7'h21, 7'h22, 7'h23, 7'h24, 7'h25, 7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C,
      7'h2D, 7'h30, 7'h31, 7'h32};
    return t[i % 41];
  endfunction

  function automatic logic [63:0] pick_val();
    case ($urandom % 6)
      0: return 64'h0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return {32'h0, $urandom} ^ {32'h0, 32'h8000_0000};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin : wdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] ea, eb, r;
    logic we, ov;
    void'($urandom(32'd20240611));

    // R13: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R13", "out_valid in reset", {65'b0, out_valid}, 66'd0);
    check(in_ready == 1'b1, "R13", "in_ready in reset", {65'b0, in_ready}, 66'd1);
    rst_n = 1'b1;

    // R1: literal zero-extended, register operand ignored
    run_op(7'h01, 64'd0, '1, 8'hFF, 1'b1, 64'd0, "R1");
    // R2: scaled forms
    run_op(7'h0B, 64'd100, 64'd3, 8'd0, 1'b0, 64'd0, "R2");
    run_op(7'h05, 64'd1, 64'd0, 8'd2, 1'b1, 64'd0, "R2");
    // R3: 32-bit add ignores upper half, sign-extends
    run_op(7'h00, 64'hFFFF_FFFF_7FFF_FFFF, 64'h1234_5678_0000_0001, 8'd0, 1'b0, 64'd0, "R3");
    // R9: same wrap on the trapping 32-bit add raises the flag
    run_op(7'h0C, 64'h0000_0000_7FFF_FFFF, 64'd1, 8'd0, 1'b0, 64'd0, "R9");
    // R9: non-trapping full-width wrap stays quiet, trapping one flags
    run_op(7'h01, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, 64'd0, "R9");
    run_op(7'h0D, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, 64'd0, "R9");
    run_op(7'h0F, 64'h8000_0000_0000_0000, 64'd1, 8'd0, 1'b0, 64'd0, "R9");
    run_op(7'h1C, 64'h4000_0000_0000_0000, 64'd2, 8'd0, 1'b0, 64'd0, "R9");
    // R4: unsigned high product of all ones
    run_op(7'h1A, '1, '1, 8'd0, 1'b0, 64'd0, "R4");
    run_op(7'h19, 64'h1_0000_0001, 64'h1_0000_0003, 8'd0, 1'b0, 64'd0, "R4");
    // R5: signed vs unsigned ordering
    run_op(7'h13, 64'd1, '1, 8'd0, 1'b0, 64'd0, "R5");
    run_op(7'h11, 64'd1, '1, 8'd0, 1'b0, 64'd0, "R5");
    run_op(7'h12, 64'd5, 64'd0, 8'd5, 1'b1, 64'd0, "R5");
    // R6
    run_op(7'h21, 64'hF0F0, 64'hFF00, 8'd0, 1'b0, 64'd0, "R6");
    // R7: failed test keeps old value, we low; passing test moves
    run_op(7'h29, 64'd0, 64'hAAAA, 8'd0, 1'b0, 64'h5555, "R7");
    run_op(7'h2A, 64'h8000_0000_0000_0000, 64'hAAAA, 8'd0, 1'b0, 64'h5555, "R7");
    run_op(7'h2D, 64'd0, 64'hAAAA, 8'd0, 1'b0, 64'h5555, "R7");
    // R8: literal 200 shifts by 8
    run_op(7'h32, 64'h8000_0000_0000_0000, 64'd0, 8'd200, 1'b1, 64'd0, "R8");
    run_op(7'h30, 64'd1, 64'hFFFF_FFFF_FFFF_FF7F, 8'd0, 1'b0, 64'd0, "R8");
    // R10: undefined code
    run_op(7'h7F, '1, '1, 8'hFF, 1'b0, '1, "R10");
    run_op(7'h15, 64'd3, 64'd3, 8'd0, 1'b0, 64'd9, "R10");

    // R11 / R12: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_fn = 7'h01; in_opa = 64'd10; in_opb = 64'd20; in_lit_sel = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && out_result == 64'd30, "R11", "first result",
          {out_result, out_valid, 1'b0}, {64'd30, 1'b1, 1'b0});
    check(in_ready == 1'b0, "R12", "stalled in_ready", {65'b0, in_ready}, 66'd0);
    in_fn = 7'h03; in_opa = 64'd50; in_opb = 64'd8;
    @(negedge clk);
    check(out_valid && out_result == 64'd30, "R12", "held result",
          {out_result, out_valid, 1'b0}, {64'd30, 1'b1, 1'b0});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == 64'd42, "R11", "second result",
          {out_result, out_valid, 1'b0}, {64'd42, 1'b1, 1'b0});
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "drained", {65'b0, out_valid}, 66'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] fn;
      logic [7:0] lit;
      logic ls;
      fn = (($urandom % 20) == 0) ? 7'($urandom) : pick_code($urandom);
      ea = pick_val();
      eb = pick_val();
      lit = 8'($urandom);
      ls = 1'($urandom);
      run_op(fn, ea, eb, lit, ls, {$urandom, $urandom}, req_of(fn));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule